// File: doc/BRIEF.md
# Asynchronous Octet-Stuffing Framer

This block carries frames over a byte-oriented asynchronous link by octet stuffing. It has two independent halves. The transmit half takes frame bytes from a valid/ready stream, each byte tagged with frame-start, frame-end and abort markers. It brackets each frame with boundary octets (0x7E) and replaces every reserved payload value with the escape octet (0x7D) followed by the value with bit 5 inverted. It can also close a frame deliberately with an abort pair.

The receive half takes raw line octets from a second valid/ready stream. It removes escapes, splits frames at boundary octets and marks frames that ended in an abort pair. A 32-bit escape map lets the user reserve any of the values 0x00 to 0x1F, such as flow-control characters. The transmitter escapes those values. The receiver discards them as line noise when they arrive unescaped. The receiver holds one decoded byte back so that it can tag the final byte of each frame.

Top module: `octet_framer`

## Requirements
- R1: After reset, tx_out_valid and rx_out_valid are 0, and tx_in_ready and rx_in_ready are 1.
- R2: A transmit beat with tx_in_sof=1 is preceded on tx_out by a 0x7E octet. A beat with tx_in_eof=1 is followed by a 0x7E octet.
- R3: A transmit payload byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20: 0x7E gives 0x7D 0x5E, and 0x7D gives 0x7D 0x5D.
- R4: A payload byte v below 0x20 is sent as 0x7D, v XOR 0x20 when bit v of esc_map is 1, and sent unchanged when that bit is 0.
- R5: A transmit beat with tx_in_abort=1 produces exactly the two octets 0x7D 0x7E, whatever tx_in_data, tx_in_sof and tx_in_eof hold.
- R6: tx_in_ready is 0 in the cycle after the encoder accepts a beat that needs a second or later output octet: an escaped byte, a start, an end or an abort. It returns to 1 once the last octet of that beat has been taken.
- R7: While tx_out_valid or rx_out_valid is 1 and its ready is 0, that output's valid and data (and, on the receive side, its last and abort tags) stay unchanged.
- R8: The receiver turns 0x7D followed by x into the data byte x XOR 0x20, whether or not that value is set in esc_map.
- R9: The receiver marks with rx_out_last=1 the data byte that comes just before a 0x7E. All other data bytes carry rx_out_last=0.
- R10: The receiver discards an unescaped byte v below 0x20 when bit v of esc_map is 1, and nothing appears on rx_out for it.
- R11: Back-to-back 0x7E octets with no data between them produce nothing on rx_out.
- R12: When the pair 0x7D 0x7E arrives, the receiver delivers the frame's last byte with both rx_out_last=1 and rx_out_abort=1. An abort pair in a frame with no data produces nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| esc_map | input | 32 | One bit per value 0x00..0x1F that is reserved |
| tx_in_valid | input | 1 | Transmit payload beat valid |
| tx_in_ready | output | 1 | Encoder accepts a beat |
| tx_in_data | input | 8 | Transmit payload byte |
| tx_in_sof | input | 1 | Beat is the first byte of a frame |
| tx_in_eof | input | 1 | Beat is the last byte of a frame |
| tx_in_abort | input | 1 | Beat is an abort request and carries no data |
| tx_out_valid | output | 1 | Line octet valid |
| tx_out_ready | input | 1 | Line side takes the octet |
| tx_out_data | output | 8 | Encoded line octet |
| rx_in_valid | input | 1 | Raw line octet valid |
| rx_in_ready | output | 1 | Decoder accepts an octet |
| rx_in_data | input | 8 | Raw line octet |
| rx_out_valid | output | 1 | Decoded byte valid |
| rx_out_ready | input | 1 | Consumer takes the decoded byte |
| rx_out_data | output | 8 | Decoded byte |
| rx_out_last | output | 1 | Byte ends its frame |
| rx_out_abort | output | 1 | Frame ended with an abort pair |

## Verification
The encoder registers its output, so the first octet of an accepted beat appears on tx_out in the cycle after the accepting edge. Each further octet of the expansion follows one cycle after the previous one was taken. The decoder holds one byte back, so a decoded byte appears on rx_out one cycle after the edge that accepts the next data octet, boundary octet or abort pair. The bench does not count cycles for these results. A scoreboard queues the expected octets and tagged bytes in order, and monitors compare them at the falling edge whenever valid and ready are both high. Fixed-cycle checks are used only where a cycle is pinned down: the ready drop and recovery around an escape, and the hold of a stalled output.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_OCTET  = 8'h7D;
  localparam logic [BYTE_W-1:0] FLIP_MASK  = 8'h20;

  typedef enum logic [2:0] {
    EP_IDLE,
    EP_BODY,
    EP_SECOND,
    EP_CLOSE,
    EP_ABORT
  } enc_phase_e;
endpackage

// File: rtl/frm_rst_sync.sv
module frm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/frm_reserved_check.sv
module frm_reserved_check
  import framer_pkg::*;
#(
  parameter int unsigned MAP_W     = 32,
  parameter bit          CTRL_TOO  = 1'b1
) (
  input  logic [BYTE_W-1:0] octet,
  input  logic [MAP_W-1:0]  map,
  output logic              hit
);
  localparam int unsigned IDX_W = (MAP_W > 1) ? $clog2(MAP_W) : 1;

  logic in_range;
  logic map_hit;

  assign in_range = (int'(octet) < int'(MAP_W));
  assign map_hit  = in_range && map[octet[IDX_W-1:0]];

  generate
    if (CTRL_TOO) begin : g_with_ctrl
      assign hit = map_hit || (octet == FLAG_OCTET) || (octet == ESC_OCTET);
    end else begin : g_map_only
      assign hit = map_hit;
    end
  endgenerate
endmodule

// File: rtl/frm_encoder.sv
module frm_encoder
  import framer_pkg::*;
#(
  parameter int unsigned MAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_W-1:0]  esc_map,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_abort,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  enc_phase_e        phase_q, phase_d;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_eof_q;
  logic              out_valid_q;
  logic [BYTE_W-1:0] out_data_q;

  logic              out_free;
  logic              take;
  logic [BYTE_W-1:0] cur_byte;
  logic              cur_esc;
  logic              emit;
  logic [BYTE_W-1:0] emit_data;

  assign out_free = !out_valid_q || out_ready;
  assign in_ready = out_free && (phase_q == EP_IDLE);
  assign take     = in_valid && in_ready;
  assign cur_byte = (phase_q == EP_IDLE) ? in_data : hold_q;

  frm_reserved_check #(.MAP_W(MAP_W), .CTRL_TOO(1'b1)) u_check (
    .octet (cur_byte),
    .map   (esc_map),
    .hit   (cur_esc)
  );

  always_comb begin
    phase_d   = phase_q;
    emit      = 1'b0;
    emit_data = out_data_q;
    case (phase_q)
      EP_IDLE: begin
        if (take) begin
          emit = 1'b1;
          if (in_abort) begin
            emit_data = ESC_OCTET;
            phase_d   = EP_ABORT;
          end else if (in_sof) begin
            emit_data = FLAG_OCTET;
            phase_d   = EP_BODY;
          end else if (cur_esc) begin
            emit_data = ESC_OCTET;
            phase_d   = EP_SECOND;
          end else begin
            emit_data = in_data;
            phase_d   = in_eof ? EP_CLOSE : EP_IDLE;
          end
        end
      end
      EP_BODY: begin
        if (out_free) begin
          emit = 1'b1;
          if (cur_esc) begin
            emit_data = ESC_OCTET;
            phase_d   = EP_SECOND;
          end else begin
            emit_data = hold_q;
            phase_d   = hold_eof_q ? EP_CLOSE : EP_IDLE;
          end
        end
      end
      EP_SECOND: begin
        if (out_free) begin
          emit      = 1'b1;
          emit_data = hold_q ^ FLIP_MASK;
          phase_d   = hold_eof_q ? EP_CLOSE : EP_IDLE;
        end
      end
      EP_CLOSE, EP_ABORT: begin
        if (out_free) begin
          emit      = 1'b1;
          emit_data = FLAG_OCTET;
          phase_d   = EP_IDLE;
        end
      end
      default: phase_d = EP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= EP_IDLE;
      hold_q      <= '0;
      hold_eof_q  <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (take) begin
        hold_q     <= in_data;
        hold_eof_q <= in_eof;
      end
      if (out_free) begin
        out_valid_q <= emit;
        if (emit) begin
          out_data_q <= emit_data;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
endmodule

// File: rtl/frm_decoder.sv
module frm_decoder
  import framer_pkg::*;
#(
  parameter int unsigned MAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_W-1:0]  esc_map,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_abort
);
  logic              esc_q, esc_d;
  logic              hold_valid_q, hold_valid_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              out_valid_q;
  logic [BYTE_W-1:0] out_data_q;
  logic              out_last_q;
  logic              out_abort_q;

  logic              out_free;
  logic              take;
  logic              noise;
  logic              emit;
  logic              emit_last;
  logic              emit_abort;
  logic [BYTE_W-1:0] plain;

  assign out_free = !out_valid_q || out_ready;
  assign in_ready = out_free;
  assign take     = in_valid && out_free;
  assign plain    = esc_q ? (in_data ^ FLIP_MASK) : in_data;

  frm_reserved_check #(.MAP_W(MAP_W), .CTRL_TOO(1'b0)) u_check (
    .octet (in_data),
    .map   (esc_map),
    .hit   (noise)
  );

  always_comb begin
    esc_d        = esc_q;
    hold_valid_d = hold_valid_q;
    hold_d       = hold_q;
    emit         = 1'b0;
    emit_last    = 1'b0;
    emit_abort   = 1'b0;
    if (take) begin
      if (esc_q && (in_data == FLAG_OCTET)) begin
        esc_d        = 1'b0;
        emit         = hold_valid_q;
        emit_last    = 1'b1;
        emit_abort   = 1'b1;
        hold_valid_d = 1'b0;
      end else if (esc_q) begin
        esc_d        = 1'b0;
        emit         = hold_valid_q;
        hold_d       = plain;
        hold_valid_d = 1'b1;
      end else if (in_data == ESC_OCTET) begin
        esc_d = 1'b1;
      end else if (in_data == FLAG_OCTET) begin
        emit         = hold_valid_q;
        emit_last    = 1'b1;
        hold_valid_d = 1'b0;
      end else if (!noise) begin
        emit         = hold_valid_q;
        hold_d       = plain;
        hold_valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_q        <= 1'b0;
      hold_valid_q <= 1'b0;
      hold_q       <= '0;
      out_valid_q  <= 1'b0;
      out_data_q   <= '0;
      out_last_q   <= 1'b0;
      out_abort_q  <= 1'b0;
    end else begin
      if (take) begin
        esc_q        <= esc_d;
        hold_valid_q <= hold_valid_d;
        hold_q       <= hold_d;
      end
      if (out_free) begin
        out_valid_q <= emit;
        if (emit) begin
          out_data_q  <= hold_q;
          out_last_q  <= emit_last;
          out_abort_q <= emit_abort;
        end
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;
  assign out_abort = out_abort_q;
endmodule

// File: rtl/octet_framer.sv
module octet_framer
  import framer_pkg::*;
#(
  parameter int unsigned MAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAP_W-1:0]  esc_map,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [BYTE_W-1:0] tx_in_data,
  input  logic              tx_in_sof,
  input  logic              tx_in_eof,
  input  logic              tx_in_abort,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [BYTE_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [BYTE_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [BYTE_W-1:0] rx_out_data,
  output logic              rx_out_last,
  output logic              rx_out_abort
);
  logic core_rst_n;

  frm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  frm_encoder #(.MAP_W(MAP_W)) u_enc (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .esc_map   (esc_map),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .in_sof    (tx_in_sof),
    .in_eof    (tx_in_eof),
    .in_abort  (tx_in_abort),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data)
  );

  frm_decoder #(.MAP_W(MAP_W)) u_dec (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .esc_map   (esc_map),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (rx_in_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .out_last  (rx_out_last),
    .out_abort (rx_out_abort)
  );
endmodule

// File: rtl/octet_framer_chk.sv
module octet_framer_chk
  import framer_pkg::*;
#(
  parameter int unsigned MAP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_in_valid,
  input logic              tx_in_ready,
  input logic [BYTE_W-1:0] tx_in_data,
  input logic              tx_in_sof,
  input logic              tx_in_eof,
  input logic              tx_in_abort,
  input logic              tx_out_valid,
  input logic              tx_out_ready,
  input logic [BYTE_W-1:0] tx_out_data,
  input logic              rx_out_valid,
  input logic              rx_out_ready,
  input logic [BYTE_W-1:0] rx_out_data,
  input logic              rx_out_last,
  input logic              rx_out_abort
);
  logic tx_take;
  assign tx_take = tx_in_valid && tx_in_ready;

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)))
    else $error("tx output changed while stalled");

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && !rx_out_ready) |=>
      (rx_out_valid && $stable(rx_out_data) && $stable(rx_out_last) && $stable(rx_out_abort)))
    else $error("rx output changed while stalled");

  assert_abort_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_in_abort) |=> (tx_out_valid && tx_out_data == ESC_OCTET))
    else $error("abort did not start with escape octet");

  assert_open_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_in_sof && !tx_in_abort) |=> (tx_out_valid && tx_out_data == FLAG_OCTET))
    else $error("frame start did not emit boundary octet");

  assert_ready_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && (tx_in_abort || tx_in_sof || tx_in_eof ||
                 tx_in_data == FLAG_OCTET || tx_in_data == ESC_OCTET)) |=> !tx_in_ready)
    else $error("ready stayed high during multi-octet beat");

  assert_abort_is_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid && rx_out_abort) |-> rx_out_last)
    else $error("abort tag without last tag");
endmodule

bind octet_framer octet_framer_chk #(.MAP_W(MAP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_in_valid  (tx_in_valid),
  .tx_in_ready  (tx_in_ready),
  .tx_in_data   (tx_in_data),
  .tx_in_sof    (tx_in_sof),
  .tx_in_eof    (tx_in_eof),
  .tx_in_abort  (tx_in_abort),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_data  (tx_out_data),
  .rx_out_valid (rx_out_valid),
  .rx_out_ready (rx_out_ready),
  .rx_out_data  (rx_out_data),
  .rx_out_last  (rx_out_last),
  .rx_out_abort (rx_out_abort)
);

// File: tb/octet_framer_tb.sv
module octet_framer_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] esc_map;
  logic        tx_in_valid, tx_in_ready, tx_in_sof, tx_in_eof, tx_in_abort;
  logic [7:0]  tx_in_data;
  logic        tx_out_valid, tx_out_ready;
  logic [7:0]  tx_out_data;
  logic        rx_in_valid, rx_in_ready;
  logic [7:0]  rx_in_data;
  logic        rx_out_valid, rx_out_ready, rx_out_last, rx_out_abort;
  logic [7:0]  rx_out_data;

  typedef struct {
    logic [7:0] d;
    logic       last;
    logic       ab;
    string      req;
  } item_t;

  item_t tx_q[$];
  item_t rx_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    bp_on  = 0;
  int    bp_cnt = 0;

  octet_framer u_dut (
    .clk(clk), .rst_n(rst_n), .esc_map(esc_map),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_in_sof(tx_in_sof), .tx_in_eof(tx_in_eof), .tx_in_abort(tx_in_abort),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .rx_out_last(rx_out_last), .rx_out_abort(rx_out_abort)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Backpressure changes just after the rising edge, away from sampling.
  always @(posedge clk) begin
    #1;
    bp_cnt = bp_cnt + 1;
    tx_out_ready = bp_on ? ((bp_cnt % 4) != 1) : 1'b1;
    rx_out_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit needs_esc(input logic [7:0] d);
    return (d == 8'h7E) || (d == 8'h7D) || ((d < 8'h20) && esc_map[d[4:0]]);
  endfunction

  task automatic exp_tx(input logic [7:0] d, input string req);
    item_t it;
    it.d = d; it.last = 1'b0; it.ab = 1'b0; it.req = req;
    tx_q.push_back(it);
  endtask

  task automatic exp_rx(input logic [7:0] d, input logic last, input logic ab,
                        input string req);
    item_t it;
    it.d = d; it.last = last; it.ab = ab; it.req = req;
    rx_q.push_back(it);
  endtask

  task automatic send_tx(input logic [7:0] d, input logic s, input logic e,
                         input logic a, input string req);
    if (a) begin
      exp_tx(8'h7D, req); exp_tx(8'h7E, req);
    end else begin
      if (s) exp_tx(8'h7E, req);
      if (needs_esc(d)) begin
        exp_tx(8'h7D, req); exp_tx(d ^ 8'h20, req);
      end else begin
        exp_tx(d, req);
      end
      if (e) exp_tx(8'h7E, req);
    end
    tx_in_valid = 1'b1; tx_in_data = d; tx_in_sof = s; tx_in_eof = e; tx_in_abort = a;
    while (!tx_in_ready) @(negedge clk);
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_sof = 1'b0; tx_in_eof = 1'b0; tx_in_abort = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d;
    while (!rx_in_ready) @(negedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  // Transmit monitor and stall checker.
  bit         tx_stall_prev = 0;
  logic [7:0] tx_data_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_stall_prev)
        check(tx_out_valid && tx_out_data == tx_data_prev, "R7", "tx stall hold",
              int'(tx_out_data), int'(tx_data_prev));
      tx_stall_prev = tx_out_valid && !tx_out_ready;
      tx_data_prev  = tx_out_data;
      if (tx_out_valid && tx_out_ready) begin
        if (tx_q.size() == 0) begin
          check(1'b0, "R2", "unexpected tx octet", int'(tx_out_data), 0);
        end else begin
          item_t it;
          it = tx_q.pop_front();
          check(tx_out_data == it.d, it.req, "tx octet", int'(tx_out_data), int'(it.d));
        end
      end
    end
  end

  // Receive monitor and stall checker.
  bit         rx_stall_prev = 0;
  logic [9:0] rx_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_stall_prev)
        check(rx_out_valid && {rx_out_abort, rx_out_last, rx_out_data} == rx_prev, "R7",
              "rx stall hold", int'({rx_out_abort, rx_out_last, rx_out_data}), int'(rx_prev));
      rx_stall_prev = rx_out_valid && !rx_out_ready;
      rx_prev       = {rx_out_abort, rx_out_last, rx_out_data};
      if (rx_out_valid && rx_out_ready) begin
        if (rx_q.size() == 0) begin
          check(1'b0, "R11", "unexpected rx byte",
                int'({rx_out_abort, rx_out_last, rx_out_data}), 0);
        end else begin
          item_t it;
          it = rx_q.pop_front();
          check({rx_out_abort, rx_out_last, rx_out_data} == {it.ab, it.last, it.d}, it.req,
                "rx byte {abort,last,data}", int'({rx_out_abort, rx_out_last, rx_out_data}),
                int'({it.ab, it.last, it.d}));
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; esc_map = 32'h000A_0001;
    tx_in_valid = 0; tx_in_data = 0; tx_in_sof = 0; tx_in_eof = 0; tx_in_abort = 0;
    rx_in_valid = 0; rx_in_data = 0;
    tx_out_ready = 1; rx_out_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tx_out_valid == 0, "R1", "tx_out_valid", int'(tx_out_valid), 0);
    check(rx_out_valid == 0, "R1", "rx_out_valid", int'(rx_out_valid), 0);
    check(tx_in_ready == 1, "R1", "tx_in_ready", int'(tx_in_ready), 1);
    check(rx_in_ready == 1, "R1", "rx_in_ready", int'(rx_in_ready), 1);

    // Encoder: mixed frame, R2 R3 R4
    send_tx(8'h41, 1, 0, 0, "R2");
    send_tx(8'h7E, 0, 0, 0, "R3");
    send_tx(8'h7D, 0, 0, 0, "R3");
    send_tx(8'h11, 0, 0, 0, "R4");
    send_tx(8'h12, 0, 0, 0, "R4");
    send_tx(8'h00, 0, 1, 0, "R4");
    drain();
    send_tx(8'h55, 1, 1, 0, "R2");
    send_tx(8'hA5, 1, 1, 1, "R5");
    drain();

    // R6: ready gap around an escape pair
    send_tx(8'h7E, 0, 0, 0, "R3");
    check(tx_in_ready == 0, "R6", "ready during second octet", int'(tx_in_ready), 0);
    @(negedge clk);
    check(tx_in_ready == 1, "R6", "ready after pair", int'(tx_in_ready), 1);
    drain();

    // Encoder under backpressure, R7
    bp_on = 1;
    send_tx(8'h30, 1, 0, 0, "R7");
    send_tx(8'h7D, 0, 0, 0, "R7");
    send_tx(8'h13, 0, 0, 0, "R7");
    send_tx(8'h31, 0, 1, 0, "R7");
    send_tx(8'h00, 0, 0, 1, "R7");
    drain();
    bp_on = 0;
    drain();

    // Decoder: unescape and delimit, R8 R9
    exp_rx(8'h41, 0, 0, "R9"); exp_rx(8'h7E, 0, 0, "R8"); exp_rx(8'h42, 1, 0, "R9");
    send_rx(8'h7E); send_rx(8'h41); send_rx(8'h7D); send_rx(8'h5E);
    send_rx(8'h42); send_rx(8'h7E);
    // R11: empty flags
    exp_rx(8'h55, 1, 0, "R11");
    send_rx(8'h7E); send_rx(8'h7E); send_rx(8'h55); send_rx(8'h7E);
    // R10: raw mapped bytes dropped
    exp_rx(8'h61, 0, 0, "R10"); exp_rx(8'h62, 1, 0, "R10");
    send_rx(8'h11); send_rx(8'h61); send_rx(8'h00); send_rx(8'h13);
    send_rx(8'h62); send_rx(8'h7E);
    // R8: escaped mapped value kept, escaped unmapped value kept
    exp_rx(8'h11, 0, 0, "R8"); exp_rx(8'h03, 1, 0, "R8");
    send_rx(8'h7D); send_rx(8'h31); send_rx(8'h7D); send_rx(8'h23); send_rx(8'h7E);
    // R12: abort with data, then abort with no data
    exp_rx(8'h70, 0, 0, "R12"); exp_rx(8'h71, 1, 1, "R12");
    send_rx(8'h70); send_rx(8'h71); send_rx(8'h7D); send_rx(8'h7E);
    exp_rx(8'h72, 1, 0, "R12");
    send_rx(8'h7E); send_rx(8'h7D); send_rx(8'h7E); send_rx(8'h72); send_rx(8'h7E);
    drain();

    // Decoder under backpressure, R7
    bp_on = 1;
    exp_rx(8'h10, 0, 0, "R7"); exp_rx(8'h7D, 0, 0, "R7"); exp_rx(8'h20, 1, 0, "R7");
    send_rx(8'h10); send_rx(8'h7D); send_rx(8'h5D); send_rx(8'h20); send_rx(8'h7E);
    drain();
    bp_on = 0;
    drain();

    // R4: map bit clear sends raw
    esc_map = 32'h0;
    @(negedge clk);
    send_tx(8'h11, 1, 1, 0, "R4");
    drain();

    check(tx_q.size() == 0, "R2", "tx queue empty", tx_q.size(), 0);
    check(rx_q.size() == 0, "R9", "rx queue empty", rx_q.size(), 0);
    summary();
    $finish;
  end
endmodule